// File: doc/BRIEF.md
# Shared-Pin Parallel Port Controller

This block controls one bidirectional parallel port of a small microcontroller. A CPU reaches four registers over a simple register bus. They hold the output data, the per-pin direction, the per-pin pullup request and the per-pin open-drain choice. For each pad the block produces an output value, an output enable and a pullup enable. It also forms the value the CPU reads back from the data register.

Several pads are shared with on-chip peripherals. Three of them can be taken over by a serial peripheral as clock, data out and data in. Two pads feed timer inputs, and one of these can also carry a timer event output. Pad levels pass through a two-flop synchronizer before the CPU or the peripherals see them. The serial peripheral, the timer and the pad cells are outside the block. Their signals enter and leave as ports.

Top module: `gpio_share_port`

## Requirements
- R1: Reset clears the direction, pullup and open-drain registers to 0, so every pad has pad_oe = 0. Reset leaves the data latch unchanged, and a later read with the direction set to output returns the value written before reset.
- R2: The bus select is 0 for data, 1 for direction, 2 for pullup and 3 for open-drain. A write is taken on the clock edge where bus_wr is 1. Reads are combinational and return the stored value. Open-drain bits 7 and 6 are not implemented and read 0.
- R3: A data-register read returns the latch in bits whose direction bit is 1. In bits whose direction bit is 0 it returns the pad level, which becomes visible two clock edges after the pad changes.
- R4: A pad that is not taken over by a peripheral drives its latch bit, with pad_oe equal to its direction bit. Writes to the latch are accepted at all times.
- R5: With spi_en = 1, pad 1 drives spi_sdo_out and pad 0 is an input. Pad 2 drives spi_sck_out when spi_master = 1 and is an input when spi_master = 0. With spi_en = 0 these three pads follow R4. Synchronized pads 2 and 0 are always forwarded to spi_sck_in and spi_sdi_in.
- R6: Latch writes never change the value on a pad that is driven by a peripheral output.
- R7: Pads 3 and 4 always take their enable from their own direction bits, whatever the timer does. Their synchronized levels go to tmr_cap_in (pad 3) and tmr_evi_in (pad 4).
- R8: With tmr_evo_en = 1, pad 4 outputs tmr_evo_out in place of its latch bit. The pad is driven only while direction bit 4 is 1.
- R9: When the open-drain bit of pad 0 to 5 is set, the pad keeps its output enable only while its value is 0. It is released when the value is 1. This holds for general-purpose and peripheral values alike.
- R10: pad_pu is the pullup register bit, forced to 0 while the pad drives a low level (pad_oe = 1 and pad_out = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pullup enables |
| spi_en | input | 1 | Serial peripheral takes over pads 2..0 |
| spi_master | input | 1 | Serial peripheral is master (clock pad drives) |
| spi_sck_out | input | 1 | Serial clock from the peripheral |
| spi_sdo_out | input | 1 | Serial data from the peripheral |
| spi_sck_in | output | 1 | Synchronized pad 2 level |
| spi_sdi_in | output | 1 | Synchronized pad 0 level |
| tmr_evo_en | input | 1 | Timer event output owns the value of pad 4 |
| tmr_evo_out | input | 1 | Timer event output value |
| tmr_cap_in | output | 1 | Synchronized pad 3 level |
| tmr_evi_in | output | 1 | Synchronized pad 4 level |

## Verification
On every cycle the assertions check four things: an open-drain pad never drives a 1, the pullup is never on against a driven low, the data-in pad is never driven while the serial peripheral owns it, and the capture pad drives only under its direction bit. They also check that the serial data pad holds steady while its source is steady, and that the direction and data readback match what was written. Some behaviour only the bench scenarios can show. That covers the latch surviving reset, the two-edge delay of pad levels into readback, and the master/slave switch of the clock pad. It also covers the timer value replacing the latch, and the readback of register combinations drawn at random.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_DATA = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_PULL = 2'd2,
      SEL_ODRN = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/gpio_share_regs.sv
module gpio_share_regs
   import gpio_share_pkg::*;
#(
   parameter int          WIDTH   = 8,
   parameter logic [WIDTH-1:0] OD_MASK = 8'h3F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_sel_e         sel,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pull_q,
   output logic [WIDTH-1:0] odrn_q
);

   // data latch has no reset: its contents survive a reset
   always_ff @(posedge clk) begin
      if (wr_en && sel == SEL_DATA) latch_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         pull_q <= '0;
         odrn_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_DIR:  dir_q  <= wdata;
            SEL_PULL: pull_q <= wdata;
            SEL_ODRN: odrn_q <= wdata & OD_MASK;
            default:  ;
         endcase
      end
   end

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_DIR) |=> (dir_q == $past(wdata)));

   // R2
   odrn_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (odrn_q & ~OD_MASK) == '0);

endmodule

// File: rtl/gpio_share_sync.sv
module gpio_share_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_share_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= async_in;
         else             stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
      end
   end

   assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_share_pinmux.sv
module gpio_share_pinmux #(
   parameter int WIDTH   = 8,
   parameter int SDI_BIT = 0,
   parameter int SDO_BIT = 1,
   parameter int SCK_BIT = 2,
   parameter int CAP_BIT = 3,
   parameter int EVT_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pull_q,
   input  logic [WIDTH-1:0] odrn_q,
   input  logic             spi_en,
   input  logic             spi_master,
   input  logic             sck_out,
   input  logic             sdo_out,
   input  logic             evo_en,
   input  logic             evo_out,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu
);

   logic [WIDTH-1:0] fn_oe;
   logic [WIDTH-1:0] fn_val;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      if (i == SCK_BIT) begin : g_sck
         assign fn_oe[i]  = spi_en ? spi_master : dir_q[i];
         assign fn_val[i] = spi_en ? sck_out    : latch_q[i];
      end else if (i == SDO_BIT) begin : g_sdo
         assign fn_oe[i]  = spi_en ? 1'b1    : dir_q[i];
         assign fn_val[i] = spi_en ? sdo_out : latch_q[i];
      end else if (i == SDI_BIT) begin : g_sdi
         assign fn_oe[i]  = spi_en ? 1'b0 : dir_q[i];
         assign fn_val[i] = latch_q[i];
      end else if (i == EVT_BIT) begin : g_evt
         assign fn_oe[i]  = dir_q[i];
         assign fn_val[i] = evo_en ? evo_out : latch_q[i];
      end else begin : g_plain
         assign fn_oe[i]  = dir_q[i];
         assign fn_val[i] = latch_q[i];
      end

      // open-drain: release the pad whenever a 1 would be driven
      assign pad_oe[i]  = fn_oe[i] & ~(odrn_q[i] & fn_val[i]);
      assign pad_out[i] = fn_val[i];
      assign pad_pu[i]  = pull_q[i] & ~(pad_oe[i] & ~pad_out[i]);
   end

   // R9
   od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (odrn_q & pad_oe & pad_out) == '0);

   // R10
   pull_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe & ~pad_out) == '0);

   // R5
   sdi_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_en |-> !pad_oe[SDI_BIT]);

   // R6
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_en && $past(spi_en) && $stable(sdo_out)) |-> $stable(pad_out[SDO_BIT]));

   // R7
   cap_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[CAP_BIT] |-> dir_q[CAP_BIT]);

endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
   import gpio_share_pkg::*;
#(
   parameter int               WIDTH       = 8,
   parameter int               SYNC_STAGES = 2,
   parameter int               SDI_BIT     = 0,
   parameter int               SDO_BIT     = 1,
   parameter int               SCK_BIT     = 2,
   parameter int               CAP_BIT     = 3,
   parameter int               EVT_BIT     = 4,
   parameter logic [WIDTH-1:0] OD_MASK     = 8'h3F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_sel,
   input  logic             bus_wr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pu,
   input  logic             spi_en,
   input  logic             spi_master,
   input  logic             spi_sck_out,
   input  logic             spi_sdo_out,
   output logic             spi_sck_in,
   output logic             spi_sdi_in,
   input  logic             tmr_evo_en,
   input  logic             tmr_evo_out,
   output logic             tmr_cap_in,
   output logic             tmr_evi_in
);

   localparam int MAX_BIT = WIDTH - 1;

   if (SDI_BIT > MAX_BIT || SDO_BIT > MAX_BIT || SCK_BIT > MAX_BIT ||
       CAP_BIT > MAX_BIT || EVT_BIT > MAX_BIT) begin : g_bad_bits
      $error("gpio_share_port: shared pad index outside the port");
   end

   reg_sel_e         sel;
   logic [WIDTH-1:0] latch_q, dir_q, pull_q, odrn_q;
   logic [WIDTH-1:0] pin_sync;

   assign sel = reg_sel_e'(bus_sel);

   gpio_share_regs #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr),
      .sel     (sel),
      .wdata   (bus_wdata),
      .latch_q (latch_q),
      .dir_q   (dir_q),
      .pull_q  (pull_q),
      .odrn_q  (odrn_q)
   );

   gpio_share_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_sync)
   );

   gpio_share_pinmux #(
      .WIDTH(WIDTH), .SDI_BIT(SDI_BIT), .SDO_BIT(SDO_BIT),
      .SCK_BIT(SCK_BIT), .CAP_BIT(CAP_BIT), .EVT_BIT(EVT_BIT)
   ) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch_q    (latch_q),
      .dir_q      (dir_q),
      .pull_q     (pull_q),
      .odrn_q     (odrn_q),
      .spi_en     (spi_en),
      .spi_master (spi_master),
      .sck_out    (spi_sck_out),
      .sdo_out    (spi_sdo_out),
      .evo_en     (tmr_evo_en),
      .evo_out    (tmr_evo_out),
      .pad_out    (pad_out),
      .pad_oe     (pad_oe),
      .pad_pu     (pad_pu)
   );

   // readback follows the direction bit, not the peripheral mode
   always_comb begin
      case (sel)
         SEL_DATA: bus_rdata = (latch_q & dir_q) | (pin_sync & ~dir_q);
         SEL_DIR:  bus_rdata = dir_q;
         SEL_PULL: bus_rdata = pull_q;
         SEL_ODRN: bus_rdata = odrn_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign spi_sck_in = pin_sync[SCK_BIT];
   assign spi_sdi_in = pin_sync[SDI_BIT];
   assign tmr_cap_in = pin_sync[CAP_BIT];
   assign tmr_evi_in = pin_sync[EVT_BIT];

   // R3
   rd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_DATA) |-> ((bus_rdata & dir_q) == (latch_q & dir_q)));

endmodule

// File: tb/gpio_share_port_test.sv
module gpio_share_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pad_in = 8'h00;
   logic [7:0] pad_out, pad_oe, pad_pu;
   logic       spi_en = 1'b0, spi_master = 1'b0, spi_sck_out = 1'b0, spi_sdo_out = 1'b0;
   logic       spi_sck_in, spi_sdi_in;
   logic       tmr_evo_en = 1'b0, tmr_evo_out = 1'b0;
   logic       tmr_cap_in, tmr_evi_in;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] m_latch, m_dir, m_pull, m_od;

   always #4 clk = ~clk;

   gpio_share_port uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .spi_en(spi_en), .spi_master(spi_master), .spi_sck_out(spi_sck_out),
      .spi_sdo_out(spi_sdo_out), .spi_sck_in(spi_sck_in), .spi_sdi_in(spi_sdi_in),
      .tmr_evo_en(tmr_evo_en), .tmr_evo_out(tmr_evo_out),
      .tmr_cap_in(tmr_cap_in), .tmr_evi_in(tmr_evi_in)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      case (sel)
         2'd0: m_latch = d;
         2'd1: m_dir   = d;
         2'd2: m_pull  = d;
         default: m_od = d & 8'h3F;
      endcase
   endtask

   task automatic read_reg(input logic [1:0] sel, output logic [7:0] d);
      bus_sel = sel;
      #1;
      d = bus_rdata;
   endtask

   // expected pad drive from the requirements (R4, R5, R8, R9, R10)
   function automatic void expect_pads(output logic [7:0] oe, output logic [7:0] val,
                                       output logic [7:0] pu);
      for (int i = 0; i < 8; i++) begin
         logic o, v;
         o = m_dir[i]; v = m_latch[i];
         if (spi_en && i == 2) begin o = spi_master; v = spi_sck_out; end
         if (spi_en && i == 1) begin o = 1'b1; v = spi_sdo_out; end
         if (spi_en && i == 0) o = 1'b0;
         if (tmr_evo_en && i == 4) v = tmr_evo_out;
         if (m_od[i] && v) o = 1'b0;
         oe[i] = o; val[i] = v; pu[i] = m_pull[i] & ~(o & ~v);
      end
   endfunction

   task automatic check_all();
      logic [7:0] eo, ev, ep, r;
      expect_pads(eo, ev, ep);
      check("R4 pad_oe", pad_oe, eo);
      check("R4 pad_out", pad_out, ev);
      check("R10 pad_pu", pad_pu, ep);
      check("R7 fwd", {4'h0, tmr_evi_in, tmr_cap_in, spi_sck_in, spi_sdi_in},
            {4'h0, pad_in[4], pad_in[3], pad_in[2], pad_in[0]});
      read_reg(2'd0, r); check("R3 data read", r, (m_latch & m_dir) | (pad_in & ~m_dir));
      read_reg(2'd1, r); check("R2 dir read", r, m_dir);
      read_reg(2'd2, r); check("R2 pull read", r, m_pull);
      read_reg(2'd3, r); check("R2 odrn read", r, m_od);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] r;
      void'($urandom(32'h1F2E3D4C));
      m_dir = 0; m_pull = 0; m_od = 0; m_latch = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 oe after reset", pad_oe, 8'h00);
      read_reg(2'd1, r); check("R1 dir reset", r, 8'h00);
      read_reg(2'd2, r); check("R1 pull reset", r, 8'h00);
      read_reg(2'd3, r); check("R1 odrn reset", r, 8'h00);

      // R1 latch survives reset
      write_reg(2'd0, 8'hA5);
      rst_n = 1'b0; m_dir = 0; m_pull = 0; m_od = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      write_reg(2'd1, 8'hFF);
      read_reg(2'd0, r); check("R1 latch kept", r, 8'hA5);
      check("R1 latch driven", pad_out, 8'hA5);

      // R2 open-drain upper bits read 0
      write_reg(2'd3, 8'hFF);
      read_reg(2'd3, r); check("R2 odrn mask", r, 8'h3F);
      check("R9 od release", pad_oe, 8'hC0 | ~8'hA5 & 8'h3F);
      write_reg(2'd3, 8'h00);

      // R3 two-edge synchronizer delay
      write_reg(2'd1, 8'h00);
      pad_in = 8'h00;
      repeat (3) @(negedge clk);
      pad_in = 8'h5A;
      @(negedge clk);
      read_reg(2'd0, r); check("R3 one edge", r, 8'h00);
      @(negedge clk);
      read_reg(2'd0, r); check("R3 two edges", r, 8'h5A);

      // R5 serial takeover, master then slave
      write_reg(2'd1, 8'h00);
      spi_en = 1'b1; spi_master = 1'b1; spi_sck_out = 1'b1; spi_sdo_out = 1'b1;
      @(negedge clk);
      check("R5 master oe", pad_oe & 8'h07, 8'h06);
      check("R5 master val", pad_out & 8'h06, 8'h06);
      spi_master = 1'b0;
      #1 check("R5 slave oe", pad_oe & 8'h07, 8'h02);

      // R6 latch write while data-out pad owned
      write_reg(2'd1, 8'hFF);
      write_reg(2'd0, 8'h00);
      check("R6 sdo unchanged", {7'h0, pad_out[1]}, 8'h01);
      spi_en = 1'b0;
      #1 check("R5 released", pad_out & 8'h07, 8'h00);

      // R8 timer event output on pad 4
      write_reg(2'd0, 8'h10);
      tmr_evo_en = 1'b1; tmr_evo_out = 1'b0;
      #1 check("R8 evo value", {7'h0, pad_out[4]}, 8'h00);
      write_reg(2'd1, 8'h00);
      check("R7 evt dir", pad_oe & 8'h18, 8'h00);
      tmr_evo_en = 1'b0;

      // random sweep
      for (int n = 0; n < 300; n++) begin
         spi_en      = 1'($urandom);
         spi_master  = 1'($urandom);
         spi_sck_out = 1'($urandom);
         spi_sdo_out = 1'($urandom);
         tmr_evo_en  = 1'($urandom);
         tmr_evo_out = 1'($urandom);
         pad_in      = 8'($urandom);
         write_reg(2'($urandom), 8'($urandom));
         repeat (2) @(negedge clk);
         check_all();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule